// File: doc/BRIEF.md
# Control-Flow and Stack Sequencer

This block carries out the control-transfer instructions of an 8-bit processor with a 16-bit address space. It owns the program counter and the stack pointer. An operation is requested with a one-cycle `start` together with an operation code, an optional condition and, for restarts, a vector number. The block then runs the operation over several cycles and pulses `done` when it has finished. The zero and carry flags are inputs. They are sampled only in the start cycle, so a condition cannot change while an operation is running.

All memory traffic goes over a byte-wide port that moves one byte per cycle. `mem_re` marks a read and `mem_we` marks a write. Read data is expected on `mem_rdata` in the cycle after the address is presented. Operand bytes are fetched from the program counter, which advances past each byte it fetches. Pushes store the high byte first, downward from the stack pointer. Pops read the low byte first, upward.

A taken jump or return ends with one idle cycle. A return from interrupt also pulses `ie_set` so that the interrupt controller can re-enable interrupts.

Top module: `flow_seq`

## Requirements
- R1: Synchronous active-high `rst` sets `pc` to 0x0000 and `sp` to 0xFFFE, clears `busy` and `done`, and keeps both memory strobes low.
- R2: Absolute jump (`op_sel`=0) reads the low byte at `pc` and then the high byte at `pc`+1. If taken, it loads `pc` with {high,low} and is busy for 4 cycles. If not taken, `pc` ends 2 past its start value and the block is busy for 3 cycles. No write occurs.
- R3: With `cond_en`=0 every operation is taken. With `cond_en`=1, `cond_sel` picks the condition: 0 means Z clear, 1 means Z set, 2 means C clear, 3 means C set. Flags are sampled in the start cycle only, and later flag changes have no effect on the running operation.
- R4: Relative jump (`op_sel`=1) reads one byte at `pc` and treats it as signed. If taken, it adds the byte to `pc`+1 and is busy for 3 cycles. If not taken, `pc` ends at `pc`+1 and the block is busy for 2 cycles.
- R5: Call (`op_sel`=2) fetches a 16-bit target as in R2. If taken, it spends one internal cycle and then writes the return address. The high byte goes to `sp`-1 and then the low byte goes to `sp`-2. It leaves `sp` lowered by 2 and `pc` at the target, busy for 6 cycles. If not taken, it is busy for 3 cycles, makes no write and leaves `sp` unchanged.
- R6: Unconditional return (`op_sel`=3, `cond_en`=0) reads the low byte at `sp` and then the high byte at `sp`+1. It loads `pc`, raises `sp` by 2 and is busy for 4 cycles, the last of which is idle.
- R7: Conditional return spends one internal cycle before acting on its condition. If taken, it is busy for 5 cycles. If not taken, it is busy for 1 cycle with no memory access, and `pc` and `sp` are unchanged.
- R8: Return from interrupt (`op_sel`=4) always behaves as R6, whatever the condition inputs, and pulses `ie_set` for exactly one cycle. No other operation raises `ie_set`.
- R9: Restart (`op_sel`=5) spends one internal cycle. If taken, it then pushes `pc` as in R5 and loads `pc` with `vec_sel`×8, busy for 3 cycles. If not taken, it is busy for 1 cycle with no write.
- R10: Register jump (`op_sel`=6) copies `hl_in` into `pc` at the start edge. It makes no memory access, keeps `busy` low and pulses `done` in the next cycle.
- R11: A `start` that arrives while `busy` is high is ignored. Memory strobes are low whenever `busy` is low.
- R12: `done` is high for one cycle after each operation, and only while `busy` is low. A `start` presented in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| op_sel | input | 3 | Operation code (see requirements) |
| cond_en | input | 1 | Make the operation conditional |
| cond_sel | input | 2 | Condition select |
| vec_sel | input | 3 | Restart vector number |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| hl_in | input | 16 | Register pair used by the register jump |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| ie_set | output | 1 | Interrupt-enable pulse from return-from-interrupt |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next request. The bench leaves the completion cycle and presents a new `start` in that very cycle. It then judges the handover by the new operation's `pc` result and by `done` dropping one cycle later. The bench also presents a second `start` while a call is still in progress and judges, from the final `pc` and the cycle count, that the running call was neither redirected nor stretched. Flags are inverted right after every accepted start. Any branch that sampled them late would therefore fail its own `pc` check.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [2:0] {
        OP_JP   = 3'd0,
        OP_JR   = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4,
        OP_RST  = 3'd5,
        OP_JPHL = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        CC_ZCLR = 2'd0,
        CC_ZSET = 2'd1,
        CC_CCLR = 2'd2,
        CC_CSET = 2'd3
    } cc_e;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_RD_LO    = 4'd1,
        ST_RD_HI    = 4'd2,
        ST_RESOLVE  = 4'd3,
        ST_INTERNAL = 4'd4,
        ST_PUSH_HI  = 4'd5,
        ST_PUSH_LO  = 4'd6,
        ST_POP_LO   = 4'd7,
        ST_POP_HI   = 4'd8,
        ST_RET_FIN  = 4'd9,
        ST_STALL    = 4'd10
    } state_e;

endpackage

// File: rtl/flow_cond.sv
module flow_cond
    import flow_pkg::*;
(
    input  logic       cond_en,
    input  logic [1:0] cond_sel,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       take
);

    always_comb begin
        if (!cond_en) begin
            take = 1'b1;
        end else begin
            unique case (cc_e'(cond_sel))
                CC_ZCLR: take = !flag_z;
                CC_ZSET: take = flag_z;
                CC_CCLR: take = !flag_c;
                CC_CSET: take = flag_c;
                default: take = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/flow_target.sv
module flow_target #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int NUM_VEC  = 8,
    parameter int VEC_STEP = 8,
    localparam int VEC_W   = $clog2(NUM_VEC),
    localparam int EXT_W   = ADDR_W - DATA_W
) (
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [DATA_W-1:0] lo_in,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] abs_tgt,
    output logic [ADDR_W-1:0] rel_tgt,
    output logic [ADDR_W-1:0] vec_tgt
);

    logic [ADDR_W-1:0] offset_ext;

    // Absolute target: the byte on the bus is the high half
    assign abs_tgt    = ADDR_W'({byte_in, lo_in});
    // Signed displacement, sign bit replicated over the upper bits
    assign offset_ext = {{EXT_W{byte_in[DATA_W-1]}}, byte_in};
    assign rel_tgt    = pc_now + offset_ext;
    assign vec_tgt    = ADDR_W'(vec) * ADDR_W'(VEC_STEP);

endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter int              NUM_VEC  = 8,
    parameter int              VEC_STEP = 8,
    parameter logic [ADDR_W-1:0] SP_INIT = 16'hFFFE,
    parameter logic [ADDR_W-1:0] PC_INIT = 16'h0000,
    localparam int             VEC_W    = $clog2(NUM_VEC),
    localparam int             HI_W     = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic              cond_en,
    input  logic [1:0]        cond_sel,
    input  logic [VEC_W-1:0]  vec_sel,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [ADDR_W-1:0] hl_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic              busy,
    output logic              done,
    output logic              ie_set
);

    typedef struct packed {
        state_e             st;
        op_e                op;
        logic               take;
        logic [VEC_W-1:0]   vec;
        logic [ADDR_W-1:0]  pc;
        logic [ADDR_W-1:0]  sp;
        logic [DATA_W-1:0]  imm_lo;
        logic [ADDR_W-1:0]  tgt;
        logic               done;
    } seq_t;

    seq_t seq_q, seq_d;

    logic              cond_take;
    logic [ADDR_W-1:0] abs_tgt, rel_tgt, vec_tgt;

    flow_cond u_cond (
        .cond_en  (cond_en),
        .cond_sel (cond_sel),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .take     (cond_take)
    );

    flow_target #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_VEC  (NUM_VEC),
        .VEC_STEP (VEC_STEP)
    ) u_target (
        .pc_now  (seq_q.pc),
        .byte_in (mem_rdata),
        .lo_in   (seq_q.imm_lo),
        .vec     (seq_q.vec),
        .abs_tgt (abs_tgt),
        .rel_tgt (rel_tgt),
        .vec_tgt (vec_tgt)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        mem_addr   = seq_q.pc;
        mem_re     = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = '0;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.op   = op_e'(op_sel);
                    seq_d.take = cond_take;
                    seq_d.vec  = vec_sel;
                    unique case (op_e'(op_sel))
                        OP_JP, OP_JR, OP_CALL: seq_d.st = ST_RD_LO;
                        OP_RET:  seq_d.st = cond_en ? ST_INTERNAL : ST_POP_LO;
                        OP_RETI: begin
                            seq_d.take = 1'b1;
                            seq_d.st   = ST_POP_LO;
                        end
                        OP_RST:  seq_d.st = ST_INTERNAL;
                        OP_JPHL: begin
                            seq_d.pc   = hl_in;
                            seq_d.done = 1'b1;
                        end
                        default: seq_d.done = 1'b1;
                    endcase
                end
            end

            ST_RD_LO: begin
                mem_re   = 1'b1;
                seq_d.pc = seq_q.pc + 1'b1;
                seq_d.st = (seq_q.op == OP_JR) ? ST_RESOLVE : ST_RD_HI;
            end

            ST_RD_HI: begin
                mem_re       = 1'b1;
                seq_d.pc     = seq_q.pc + 1'b1;
                seq_d.imm_lo = mem_rdata;
                seq_d.st     = ST_RESOLVE;
            end

            ST_RESOLVE: begin
                seq_d.tgt = abs_tgt;
                if (!seq_q.take) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else if (seq_q.op == OP_CALL) begin
                    seq_d.st = ST_INTERNAL;
                end else begin
                    seq_d.pc = (seq_q.op == OP_JR) ? rel_tgt : abs_tgt;
                    seq_d.st = ST_STALL;
                end
            end

            ST_INTERNAL: begin
                if (!seq_q.take) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else if (seq_q.op == OP_RET) begin
                    seq_d.st = ST_POP_LO;
                end else begin
                    if (seq_q.op == OP_RST) begin
                        seq_d.tgt = vec_tgt;
                    end
                    seq_d.st = ST_PUSH_HI;
                end
            end

            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = seq_q.sp - 1'b1;
                mem_wdata = DATA_W'(seq_q.pc[ADDR_W-1:ADDR_W-HI_W]);
                seq_d.sp  = seq_q.sp - 1'b1;
                seq_d.st  = ST_PUSH_LO;
            end

            ST_PUSH_LO: begin
                mem_we     = 1'b1;
                mem_addr   = seq_q.sp - 1'b1;
                mem_wdata  = seq_q.pc[DATA_W-1:0];
                seq_d.sp   = seq_q.sp - 1'b1;
                seq_d.pc   = seq_q.tgt;
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end

            ST_POP_LO: begin
                mem_re   = 1'b1;
                mem_addr = seq_q.sp;
                seq_d.st = ST_POP_HI;
            end

            ST_POP_HI: begin
                mem_re       = 1'b1;
                mem_addr     = seq_q.sp + 1'b1;
                seq_d.imm_lo = mem_rdata;
                seq_d.st     = ST_RET_FIN;
            end

            ST_RET_FIN: begin
                seq_d.pc = abs_tgt;
                seq_d.sp = seq_q.sp + ADDR_W'(2);
                seq_d.st = ST_STALL;
            end

            ST_STALL: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end

            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
            seq_q.op <= OP_NONE;
            seq_q.pc <= PC_INIT;
            seq_q.sp <= SP_INIT;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc     = seq_q.pc;
    assign sp     = seq_q.sp;
    assign busy   = (seq_q.st != ST_IDLE);
    assign done   = seq_q.done;
    assign ie_set = (seq_q.st == ST_RET_FIN) && (seq_q.op == OP_RETI);

endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SP_INIT = 16'hFFFE,
    parameter logic [ADDR_W-1:0] PC_INIT = 16'h0000
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        op_sel,
    input logic [ADDR_W-1:0] hl_in,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] sp,
    input logic              busy,
    input logic              done,
    input logic              mem_re,
    input logic              mem_we,
    input logic              ie_set
);

    logic seen_q = 1'b0;

    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (pc == PC_INIT && sp == SP_INIT && !busy && !done && !mem_re && !mem_we));

    assert_pc_from_hl_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op_sel == 3'd6) |=> (pc == $past(hl_in) && !busy && done));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_re && !mem_we));

    // Covers pushes (R5, R9) and pops (R6): the stack pointer only steps down by one or up by two
    assert_sp_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sp) |-> (sp == $past(sp) - 1'b1 || sp == $past(sp) + ADDR_W'(2)));

    assert_ie_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ie_set |=> !ie_set);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind flow_seq flow_seq_chk #(
    .ADDR_W  (ADDR_W),
    .SP_INIT (SP_INIT),
    .PC_INIT (PC_INIT)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_sel (op_sel),
    .hl_in  (hl_in),
    .pc     (pc),
    .sp     (sp),
    .busy   (busy),
    .done   (done),
    .mem_re (mem_re),
    .mem_we (mem_we),
    .ie_set (ie_set)
);

// File: tb/flow_seq_tb.sv
`timescale 1ns/1ps
module flow_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_sel = 3'd7;
    logic        cond_en = 1'b0;
    logic [1:0]  cond_sel = 2'd0;
    logic [2:0]  vec_sel = 3'd0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] hl_in = 16'h0;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;
    logic [15:0] pc, sp;
    logic        busy, done, ie_set;

    always #2.5 clk = ~clk;

    flow_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .cond_en(cond_en),
        .cond_sel(cond_sel), .vec_sel(vec_sel), .flag_z(flag_z), .flag_c(flag_c),
        .hl_in(hl_in), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc(pc), .sp(sp),
        .busy(busy), .done(done), .ie_set(ie_set)
    );

    // Memory model: page 0xFF is the stack area (written by the design), the rest is code
    logic [7:0]  code_mem [256];
    logic [7:0]  stk_mem  [256];
    logic [15:0] wa [16];
    logic [7:0]  wd [16];
    logic [15:0] ra [16];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          ie_cnt = 0;

    always @(posedge clk) begin
        mem_rdata <= (mem_addr[15:8] == 8'hFF) ? stk_mem[mem_addr[7:0]] : code_mem[mem_addr[7:0]];
        if (!rst && mem_we) begin
            wa[wr_cnt[3:0]] <= mem_addr;
            wd[wr_cnt[3:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
            if (mem_addr[15:8] == 8'hFF) stk_mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (!rst && mem_re) begin
            ra[rd_cnt[3:0]] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (!rst && ie_set) ie_cnt <= ie_cnt + 1;
    end

    int n_chk  = 0;
    int n_fail = 0;
    int wr_base, rd_base, ie_base, cyc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge of the done cycle.
    task automatic run_op(input logic [2:0] op, input logic cen, input logic [1:0] csel,
                          input logic [2:0] vec, input logic fz, input logic fc,
                          input logic [15:0] hl, input bit poke);
        start = 1'b1; op_sel = op; cond_en = cen; cond_sel = csel;
        vec_sel = vec; flag_z = fz; flag_c = fc; hl_in = hl;
        wr_base = wr_cnt; rd_base = rd_cnt; ie_base = ie_cnt;
        @(negedge clk);
        start = 1'b0;
        flag_z = ~fz;            // flags flip after the start edge
        flag_c = ~fc;
        cyc = 0;
        while (!done && cyc < 100) begin
            cyc++;
            if (poke && cyc == 2) begin
                start = 1'b1; op_sel = 3'd6; hl_in = 16'hDEAD;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (cyc >= 100) chk("R12 done never seen", 32'(cyc), 32'd0);
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic        cen;
        logic [1:0]  csel;
        logic        fz;
        logic        fc;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [15:0] exp_pc;
        logic [7:0]  exp_cyc;
    } vec_t;

    localparam vec_t TBL [11] = '{
        '{3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h34, 8'h12, 16'h1234, 8'd4},
        '{3'd0, 1'b1, 2'd0, 1'b1, 1'b0, 8'h34, 8'h12, 16'h0042, 8'd3},
        '{3'd0, 1'b1, 2'd0, 1'b0, 1'b0, 8'h34, 8'h12, 16'h1234, 8'd4},
        '{3'd0, 1'b1, 2'd1, 1'b1, 1'b0, 8'h34, 8'h12, 16'h1234, 8'd4},
        '{3'd0, 1'b1, 2'd2, 1'b0, 1'b1, 8'h34, 8'h12, 16'h0042, 8'd3},
        '{3'd0, 1'b1, 2'd3, 1'b0, 1'b1, 8'h34, 8'h12, 16'h1234, 8'd4},
        '{3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h10, 8'h00, 16'h0051, 8'd3},
        '{3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 8'hFE, 8'h00, 16'h003F, 8'd3},
        '{3'd1, 1'b1, 2'd1, 1'b0, 1'b0, 8'h10, 8'h00, 16'h0041, 8'd2},
        '{3'd1, 1'b1, 2'd3, 1'b0, 1'b1, 8'h80, 8'h00, 16'hFFC1, 8'd3},
        '{3'd1, 1'b1, 2'd2, 1'b0, 1'b0, 8'h7F, 8'h00, 16'h00C0, 8'd3}
    };

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            code_mem[i] = 8'h00;
            stk_mem[i]  = 8'h00;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset pc", 32'(pc), 32'h0000);
        chk("R1 reset sp", 32'(sp), 32'hFFFE);
        chk("R1 reset busy/done", {30'd0, busy, done}, 32'd0);
        chk("R1 reset strobes", {30'd0, mem_re, mem_we}, 32'd0);

        // Table of jumps (R2, R4) with conditions (R3)
        for (int k = 0; k < 11; k++) begin
            code_mem[8'h40] = TBL[k].b0;
            code_mem[8'h41] = TBL[k].b1;
            run_op(3'd6, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h0040, 1'b0);
            run_op(TBL[k].op, TBL[k].cen, TBL[k].csel, 3'd0, TBL[k].fz, TBL[k].fc, 16'h0, 1'b0);
            if (TBL[k].op == 3'd0) begin
                chk($sformatf("R2 R3 entry %0d pc", k), 32'(pc), 32'(TBL[k].exp_pc));
                chk($sformatf("R2 entry %0d cycles", k), 32'(cyc), 32'(TBL[k].exp_cyc));
            end else begin
                chk($sformatf("R4 R3 entry %0d pc", k), 32'(pc), 32'(TBL[k].exp_pc));
                chk($sformatf("R4 entry %0d cycles", k), 32'(cyc), 32'(TBL[k].exp_cyc));
            end
            chk($sformatf("R2 R4 entry %0d no write", k), 32'(wr_cnt - wr_base), 32'd0);
        end

        // R10 register jump
        run_op(3'd6, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'hBEEF, 1'b0);
        chk("R10 pc from hl", 32'(pc), 32'hBEEF);
        chk("R10 cycles", 32'(cyc), 32'd0);
        chk("R10 no access", 32'((wr_cnt - wr_base) + (rd_cnt - rd_base)), 32'd0);

        // R5 taken call with an ignored start mid-flight (R11)
        code_mem[8'h40] = 8'h00;
        code_mem[8'h41] = 8'h30;
        run_op(3'd6, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h0040, 1'b0);
        run_op(3'd2, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b1);
        chk("R11 busy start ignored", 32'(pc), 32'h3000);
        chk("R5 call cycles", 32'(cyc), 32'd6);
        chk("R5 call sp", 32'(sp), 32'hFFFC);
        chk("R5 write count", 32'(wr_cnt - wr_base), 32'd2);
        chk("R5 first write addr", 32'(wa[wr_base[3:0]]), 32'hFFFD);
        chk("R5 first write data", 32'(wd[wr_base[3:0]]), 32'h00);
        chk("R5 second write addr", 32'(wa[4'(wr_base + 1)]), 32'hFFFC);
        chk("R5 second write data", 32'(wd[4'(wr_base + 1)]), 32'h42);

        // R5 untaken call (Z set required, Z clear given)
        run_op(3'd2, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R5 untaken pc", 32'(pc), 32'h3002);
        chk("R5 untaken cycles", 32'(cyc), 32'd3);
        chk("R5 untaken sp", 32'(sp), 32'hFFFC);
        chk("R5 untaken no write", 32'(wr_cnt - wr_base), 32'd0);

        // R6 unconditional return
        run_op(3'd3, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R6 ret pc", 32'(pc), 32'h0042);
        chk("R6 ret sp", 32'(sp), 32'hFFFE);
        chk("R6 ret cycles", 32'(cyc), 32'd4);
        chk("R6 first read addr", 32'(ra[rd_base[3:0]]), 32'hFFFC);
        chk("R6 second read addr", 32'(ra[4'(rd_base + 1)]), 32'hFFFD);
        chk("R8 no ie on plain return", 32'(ie_cnt - ie_base), 32'd0);

        // R9 restart taken and untaken
        run_op(3'd5, 1'b0, 2'd0, 3'd5, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R9 rst pc", 32'(pc), 32'h0028);
        chk("R9 rst cycles", 32'(cyc), 32'd3);
        chk("R9 rst sp", 32'(sp), 32'hFFFC);
        chk("R9 rst hi write", {wa[wr_base[3:0]], 8'h00, wd[wr_base[3:0]]}, {16'hFFFD, 8'h00, 8'h00});
        chk("R9 rst lo write", {wa[4'(wr_base + 1)], 8'h00, wd[4'(wr_base + 1)]}, {16'hFFFC, 8'h00, 8'h42});
        run_op(3'd5, 1'b1, 2'd2, 3'd7, 1'b0, 1'b1, 16'h0000, 1'b0);
        chk("R9 untaken rst pc", 32'(pc), 32'h0028);
        chk("R9 untaken rst cycles", 32'(cyc), 32'd1);
        chk("R9 untaken rst no write", 32'(wr_cnt - wr_base), 32'd0);

        // R7 conditional returns
        run_op(3'd3, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 16'h0000, 1'b0);
        chk("R7 untaken ret cycles", 32'(cyc), 32'd1);
        chk("R7 untaken ret pc/sp", {pc, sp}, {16'h0028, 16'hFFFC});
        chk("R7 untaken ret no read", 32'(rd_cnt - rd_base), 32'd0);
        run_op(3'd3, 1'b1, 2'd3, 3'd0, 1'b0, 1'b1, 16'h0000, 1'b0);
        chk("R7 taken ret cycles", 32'(cyc), 32'd5);
        chk("R7 taken ret pc/sp", {pc, sp}, {16'h0042, 16'hFFFE});

        // R8 return from interrupt ignores a false condition
        code_mem[8'h50] = 8'h00;
        code_mem[8'h51] = 8'h20;
        run_op(3'd6, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h0050, 1'b0);
        run_op(3'd2, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R5 second call pc", 32'(pc), 32'h2000);
        run_op(3'd4, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R8 reti pc/sp", {pc, sp}, {16'h0052, 16'hFFFE});
        chk("R8 reti cycles", 32'(cyc), 32'd4);
        chk("R8 ie pulse count", 32'(ie_cnt - ie_base), 32'd1);

        // R12 completion and a new request in the same cycle
        chk("R12 done cycle idle", {30'd0, done, busy}, 32'd2);
        run_op(3'd6, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 16'h0077, 1'b0);
        chk("R12 back-to-back pc", 32'(pc), 32'h0077);
        chk("R12 back-to-back cycles", 32'(cyc), 32'd0);
        @(negedge clk);
        chk("R12 done single pulse", {31'd0, done}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule